// File: doc/BRIEF.md
# BCH Syndrome Accumulation Engine

This block offloads the syndrome loop of a binary BCH decoder that corrects up to three bit errors. After a start request it walks a received codeword one bit per clock, reading it from an external bit buffer through an address output. The walk is repeated once for each of sixteen syndrome indices. In the pass for index i, every set bit at position j adds (by XOR) the field element alpha^(i*j mod n) into syndrome i. The field is GF(2^10) with n = 1023, and alpha is a root of x^10 + x^3 + 1.

No multiplier is used. An exponent register starts at zero in each pass and advances by i modulo n after each bit, so its value always equals (i*j) mod n. That value addresses an antilog table computed at elaboration. A cleared bit leaves the syndrome unchanged. The first bit of each pass overwrites the register instead of accumulating into it, so nothing from an earlier run carries over.

When the sixteenth pass finishes, the engine raises a one-cycle completion pulse. All sixteen syndromes then stay readable on a flat output vector until the next accepted start. A start request whose length is zero or greater than n is refused with a one-cycle error pulse.

Top module: `bch_syndrome_engine`

## Requirements
- R1: During and right after reset, busy, done and err are 0 and every syndrome reads 0.
- R2: A start sampled in idle with length L (1 <= L <= 1023) makes busy high from the next cycle. done is high for exactly one cycle, 16*L clock edges after the start edge, and busy is low in that cycle.
- R3: After completion, syndrome i (1..16) sits at syndromes[(i-1)*10 +: 10]. It equals the XOR over all positions j < L with rd_bit = 1 of alpha^((i*j) mod 1023), where alpha^k is reduced by x^10 + x^3 + 1 (alpha^10 = alpha^3 + 1).
- R4: In the cycle k after the start edge (k = 0 .. 16*L-1), rd_addr equals k mod L. rd_bit is sampled in that same cycle.
- R5: A codeword whose bits are all zero gives sixteen zero syndromes. This holds even when the previous run left nonzero values.
- R6: A start with length 0 or length greater than 1023 produces a one-cycle err pulse on the next cycle. busy stays low and the syndrome outputs keep their previous values.
- R7: A start asserted while busy has no effect on timing or results. Between completion and the next accepted start, the syndromes hold their values even if the buffer contents change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin a run, sampled while idle |
| length | input | 11 | Codeword length in bits for the run |
| rd_bit | input | 1 | Received bit at rd_addr, returned in the same cycle |
| rd_addr | output | 10 | Bit position being scanned |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle pulse when all syndromes are valid |
| err | output | 1 | One-cycle pulse when a start is refused for its length |
| syndromes | output | 160 | Sixteen 10-bit syndromes, index 1 in the low bits |

## Verification
The assertions assume that the bit buffer answers combinationally and that the length input is stable while it is being sampled with start. They also assume that reset is held low for at least one edge before activity begins. The bench models the buffer as a plain array indexed by rd_addr. It changes length and start only just after a clock edge. It changes buffer contents only while the engine is idle, except for one deliberate change after completion, which checks that the held results stay put.

// File: rtl/bch_syn_pkg.sv
package bch_syn_pkg;

    localparam int unsigned FIELD_M   = 10;
    localparam int unsigned NUM_SYN   = 16;
    localparam logic [FIELD_M:0] FIELD_POLY = 11'h409;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } eng_state_e;

endpackage

// File: rtl/bch_antilog_rom.sv
module bch_antilog_rom #(
    parameter int unsigned M    = 10,
    parameter logic [M:0]  POLY = 11'h409
) (
    input  logic [M-1:0] exp_i,
    output logic [M-1:0] val_o
);
    localparam int unsigned N = (1 << M) - 1;

    function automatic logic [N*M-1:0] build_table();
        logic [M:0]     v;
        logic [N*M-1:0] t;
        v = {{M{1'b0}}, 1'b1};
        t = '0;
        for (int e = 0; e < int'(N); e++) begin
            t[e*M +: M] = v[M-1:0];
            v = v << 1;
            if (v[M]) begin
                v = v ^ POLY;
            end
        end
        return t;
    endfunction

    localparam logic [N*M-1:0] ANTILOG = build_table();

    always_comb begin
        val_o = ANTILOG[int'(exp_i)*M +: M];
    end

endmodule

// File: rtl/bch_exp_stepper.sv
module bch_exp_stepper #(
    parameter int unsigned M = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         step_i,
    input  logic [M-1:0] incr_i,
    output logic [M-1:0] exp_o
);
    localparam int unsigned N = (1 << M) - 1;

    logic [M-1:0] exp_q, exp_d;
    logic [M:0]   sum;
    logic [M:0]   wrapped;

    always_comb begin
        sum     = {1'b0, exp_q} + {1'b0, incr_i};
        wrapped = (sum >= (M+1)'(N)) ? (sum - (M+1)'(N)) : sum;
        exp_d   = exp_q;
        if (clear_i) begin
            exp_d = '0;
        end else if (step_i) begin
            exp_d = wrapped[M-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_q <= '0;
        end else begin
            exp_q <= exp_d;
        end
    end

    assign exp_o = exp_q;

    AST_EXP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_q < M'(N)));  // R4

    AST_EXP_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (exp_q == '0));  // R4

endmodule

// File: rtl/bch_syn_bank.sv
module bch_syn_bank #(
    parameter int unsigned M    = 10,
    parameter int unsigned NSYN = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en_i,
    input  logic [$clog2(NSYN)-1:0]   sel_i,
    input  logic                      first_i,
    input  logic                      bit_i,
    input  logic [M-1:0]              term_i,
    output logic [NSYN*M-1:0]         syn_o
);
    typedef logic [NSYN-1:0][M-1:0] bank_t;

    bank_t        bank_q, bank_d;
    logic [M-1:0] contrib;

    always_comb begin
        contrib = bit_i ? term_i : '0;
        bank_d  = bank_q;
        for (int k = 0; k < int'(NSYN); k++) begin
            if (wr_en_i && (int'(sel_i) == k)) begin
                bank_d[k] = first_i ? contrib : (bank_q[k] ^ contrib);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign syn_o = bank_q;

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(syn_o));  // R7

    AST_ZERO_BIT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !bit_i && !first_i) |=> $stable(syn_o));  // R5

endmodule

// File: rtl/bch_syndrome_engine.sv
module bch_syndrome_engine
    import bch_syn_pkg::*;
#(
    parameter int unsigned M    = FIELD_M,
    parameter int unsigned NSYN = NUM_SYN,
    parameter logic [M:0]  POLY = FIELD_POLY
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [M:0]           length,
    input  logic                 rd_bit,
    output logic [M-1:0]         rd_addr,
    output logic                 busy,
    output logic                 done,
    output logic                 err,
    output logic [NSYN*M-1:0]    syndromes
);
    localparam int unsigned N     = (1 << M) - 1;
    localparam int unsigned LEN_W = M + 1;
    localparam int unsigned IDX_W = $clog2(NSYN);

    typedef struct packed {
        eng_state_e         state;
        logic [LEN_W-1:0]   len;
        logic [M-1:0]       pos;
        logic [IDX_W-1:0]   idx;
        logic               done;
        logic               err;
    } ctrl_t;

    ctrl_t        ctrl_q, ctrl_d;
    logic         scanning;
    logic         pass_end;
    logic         last_pass;
    logic         len_bad;
    logic         exp_clear;
    logic [M-1:0] exp_incr;
    logic [M-1:0] exp_val;
    logic [M-1:0] rom_val;

    always_comb begin
        scanning  = (ctrl_q.state == ST_SCAN);
        pass_end  = scanning && ({1'b0, ctrl_q.pos} == (ctrl_q.len - LEN_W'(1)));
        last_pass = (ctrl_q.idx == IDX_W'(NSYN - 1));
        len_bad   = (length == '0) || (length > LEN_W'(N));
        exp_clear = !scanning || pass_end;
        exp_incr  = M'(ctrl_q.idx) + M'(1);

        ctrl_d      = ctrl_q;
        ctrl_d.done = 1'b0;
        ctrl_d.err  = 1'b0;
        case (ctrl_q.state)
            ST_IDLE: begin
                if (start) begin
                    if (len_bad) begin
                        ctrl_d.err = 1'b1;
                    end else begin
                        ctrl_d.state = ST_SCAN;
                        ctrl_d.len   = length;
                        ctrl_d.pos   = '0;
                        ctrl_d.idx   = '0;
                    end
                end
            end
            ST_SCAN: begin
                if (pass_end) begin
                    ctrl_d.pos = '0;
                    if (last_pass) begin
                        ctrl_d.state = ST_IDLE;
                        ctrl_d.done  = 1'b1;
                    end else begin
                        ctrl_d.idx = ctrl_q.idx + IDX_W'(1);
                    end
                end else begin
                    ctrl_d.pos = ctrl_q.pos + M'(1);
                end
            end
            default: ctrl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '{state: ST_IDLE, len: '0, pos: '0, idx: '0, done: 1'b0, err: 1'b0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    bch_exp_stepper #(.M(M)) u_stepper (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (exp_clear),
        .step_i  (scanning),
        .incr_i  (exp_incr),
        .exp_o   (exp_val)
    );

    bch_antilog_rom #(.M(M), .POLY(POLY)) u_rom (
        .exp_i (exp_val),
        .val_o (rom_val)
    );

    bch_syn_bank #(.M(M), .NSYN(NSYN)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (scanning),
        .sel_i   (ctrl_q.idx),
        .first_i (ctrl_q.pos == '0),
        .bit_i   (rd_bit),
        .term_i  (rom_val),
        .syn_o   (syndromes)
    );

    assign rd_addr = ctrl_q.pos;
    assign busy    = scanning;
    assign done    = ctrl_q.done;
    assign err     = ctrl_q.err;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R2

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);  // R2

    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));  // R2

    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ({1'b0, rd_addr} < ctrl_q.len));  // R4

    AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && $stable(syndromes)));  // R6

    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);  // R6

endmodule

// File: tb/bch_syndrome_engine_bench.sv
module bch_syndrome_engine_bench;

    localparam int M  = 10;
    localparam int NF = 1023;
    localparam int NS = 16;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              start;
    logic [M:0]        length;
    logic              rd_bit;
    logic [M-1:0]      rd_addr;
    logic              busy;
    logic              done;
    logic              err;
    logic [NS*M-1:0]   syndromes;

    bit                cw [1024];
    int                alog [NF];
    int                exp_s [NS+1];
    int                checks   = 0;
    int                failures = 0;
    bit                finished = 1'b0;

    always #10 clk = ~clk;

    assign rd_bit = cw[rd_addr];

    bch_syndrome_engine u_bch_syndrome_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .length    (length),
        .rd_bit    (rd_bit),
        .rd_addr   (rd_addr),
        .busy      (busy),
        .done      (done),
        .err       (err),
        .syndromes (syndromes)
    );

    // {length, seed, mode}: mode 0 random fill, mode 1 three set bits
    localparam int VEC [8][3] = '{
        '{64,   32'h1234, 0},
        '{1023, 32'h9e37, 0},
        '{1,    32'h0001, 0},
        '{100,  32'h5555, 1},
        '{512,  32'hbeef, 0},
        '{255,  32'h0707, 1},
        '{700,  32'hc0de, 0},
        '{300,  32'h0042, 1}
    };

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic void build_alog();
        logic [M:0] v;
        v = 11'd1;
        for (int e = 0; e < NF; e++) begin
            alog[e] = int'(v[M-1:0]);
            v = v << 1;
            if (v[M]) v = v ^ 11'h409;
        end
    endfunction

    function automatic void model(input int len);
        for (int i = 1; i <= NS; i++) begin
            int acc;
            acc = 0;
            for (int j = 0; j < len; j++) begin
                if (cw[j]) acc = acc ^ alog[(i * j) % NF];
            end
            exp_s[i] = acc;
        end
    endfunction

    function automatic void fill(input int len, input logic [31:0] seed, input int mode);
        logic [31:0] s;
        s = seed;
        for (int j = 0; j < 1024; j++) cw[j] = 1'b0;
        if (mode == 0) begin
            for (int j = 0; j < len; j++) begin
                s = s * 32'd1103515245 + 32'd12345;
                cw[j] = s[16];
            end
        end else begin
            cw[int'(seed) % len]        = 1'b1;
            cw[(int'(seed) * 7) % len]  = 1'b1;
            cw[(int'(seed) * 13) % len] = 1'b1;
        end
    endfunction

    task automatic compare_syn(input string req);
        for (int i = 1; i <= NS; i++) begin
            int got;
            got = int'(syndromes[(i-1)*M +: M]);
            check(got == exp_s[i], req, got, exp_s[i]);
        end
    endtask

    // Starts a run and waits for done; checks R2 timing and the R4 address walk.
    task automatic run(input int len, input int busy_poke);
        int cyc;
        int addr_bad;
        addr_bad = 0;
        length = (M+1)'(len);
        start  = 1'b1;
        @(posedge clk); #1;
        start  = 1'b0;
        check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
        cyc = 0;
        while (!done && cyc < 20000) begin
            if (busy && (int'(rd_addr) != (cyc % len))) addr_bad++;
            if (busy_poke > 0 && cyc == busy_poke) begin
                length = 11'd1;
                start  = 1'b1;
            end
            @(posedge clk); #1;
            start = 1'b0;
            cyc++;
        end
        check(cyc == 16 * len, "R2 cycles to done", cyc, 16 * len);
        check(busy == 1'b0, "R2 idle at done", int'(busy), 0);
        check(addr_bad == 0, "R4 address walk", addr_bad, 0);
        @(posedge clk); #1;
        check(done == 1'b0, "R2 done one cycle", int'(done), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [NS*M-1:0] snap;
        build_alog();
        rst_n  = 1'b0;
        start  = 1'b0;
        length = '0;
        for (int j = 0; j < 1024; j++) cw[j] = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check(busy == 1'b0, "R1 busy", int'(busy), 0);
        check(done == 1'b0, "R1 done", int'(done), 0);
        check(err == 1'b0, "R1 err", int'(err), 0);
        check(syndromes == '0, "R1 syndromes", int'(syndromes[M-1:0]), 0);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R3 table of codewords against the software model
        for (int v = 0; v < 8; v++) begin
            fill(VEC[v][0], VEC[v][1], VEC[v][2]);
            model(VEC[v][0]);
            run(VEC[v][0], 0);
            compare_syn("R3 vector");
        end

        // R3 single bit: syndrome i = alpha^(5i)
        fill(10, 32'd0, 1);
        for (int j = 0; j < 1024; j++) cw[j] = 1'b0;
        cw[5] = 1'b1;
        model(10);
        run(10, 0);
        for (int i = 1; i <= NS; i++) begin
            check(int'(syndromes[(i-1)*M +: M]) == alog[(5 * i) % NF], "R3 single bit",
                  int'(syndromes[(i-1)*M +: M]), alog[(5 * i) % NF]);
        end

        // R5 all-zero codeword after a nonzero result
        for (int j = 0; j < 1024; j++) cw[j] = 1'b0;
        run(200, 0);
        check(syndromes == '0, "R5 zero codeword", int'(syndromes[M-1:0]), 0);

        // R6 refused lengths; syndromes kept
        fill(64, 32'h77, 0);
        model(64);
        run(64, 0);
        snap = syndromes;
        length = 11'd1024;
        start  = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        check(err == 1'b1, "R6 err for 1024", int'(err), 1);
        check(busy == 1'b0, "R6 no busy for 1024", int'(busy), 0);
        @(posedge clk); #1;
        check(err == 1'b0, "R6 err one cycle", int'(err), 0);
        length = 11'd0;
        start  = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        check(err == 1'b1, "R6 err for zero", int'(err), 1);
        check(busy == 1'b0, "R6 no busy for zero", int'(busy), 0);
        @(posedge clk); #1;
        check(syndromes == snap, "R6 syndromes kept", 0, 0);

        // R7 hold after done while buffer changes
        for (int j = 0; j < 1024; j++) cw[j] = 1'b1;
        repeat (5) @(posedge clk);
        #1;
        check(syndromes == snap, "R7 hold after done", 0, 0);

        // R7 start while busy ignored
        fill(80, 32'h3141, 0);
        model(80);
        run(80, 30);
        compare_syn("R7 busy start ignored");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule